// File: doc/BRIEF.md
# Recirculating Text Row Store

This block keeps one text row of a character-mode display: a byte of character code and a byte of attribute for each cell. Each kind of byte lives in its own shift register with one stage per cell. The last stage feeds back to the first, so one full rotation takes exactly one raster line of cells. The display logic only ever sees the last stage, the tap. Because of this, no address counter is needed: each time a cell is shifted, the next cell of the row appears at the tap.

Fetched bytes come in on a pair of fetch lines at a row boundary. On the first line of the pair, each fetched character code replaces the recirculated byte at the feedback point. The old row's code, which is still at the tap, is shown during that line. On the second line of the pair, each fetched attribute is stored in the same way. It is also sent straight to the attribute output, because the old row's attribute is no longer valid at that point. Both outputs are registered, so a value shows one cycle after the cell shift that selects it.

While the shift enable is low, nothing moves. The row keeps its phase across blanking.

Top module: `txt_row_recirc`

## Requirements
- R1: A synchronous active-high `rst` sets `cur_code` and `cur_attr` to zero and clears every stored cell to zero. After reset, a full line of shifts with no fetch shows zero codes and zero attributes.
- R2: Cells are numbered by the count of shifts since reset, modulo CELLS. With no write, the byte shown for a cell is the byte shown or stored for it CELLS shifts earlier, so the row repeats once per line.
- R3: A code write happens on a shift when `fetch_valid`=1, `fetch_sel`=0 (code) and `pair_second`=0 (first line of a pair). `fetch_data` replaces that cell's stored code. `cur_code` still shows the cell's previous code.
- R4: An attribute write happens on a shift when `fetch_valid`=1, `fetch_sel`=1 (attribute) and `pair_second`=1 (second line of a pair). `fetch_data` replaces that cell's stored attribute. The same byte appears on `cur_attr` after that clock edge.
- R5: On the second fetch line, `cur_code` shows the codes that were written on the first line, each in the cell it was written to.
- R6: A fetched byte is ignored, with the stored row left unchanged, in three cases: `fetch_valid`=0, `fetch_sel`=0 with `pair_second`=1, or `fetch_sel`=1 with `pair_second`=0.
- R7: While `shift_en`=0, `cur_code` and `cur_attr` hold their values and the row does not advance. Shifting continues from the same cell when `shift_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advance one cell this cycle |
| fetch_valid | input | 1 | `fetch_data` carries a fetched byte |
| fetch_sel | input | 1 | Target of the fetch: 0 code, 1 attribute |
| pair_second | input | 1 | 0 first fetch line of a pair, 1 second |
| fetch_data | input | W | Fetched byte |
| cur_code | output | W | Code of the current cell, for glyph lookup |
| cur_attr | output | W | Attribute of the current cell, for colour |

## Verification
The row is run through several kinds of line. A plain line after reset shows that the store is cleared. A first-line fetch of codes tells the old displayed code apart from the new stored one. A second-line fetch of attributes tells the fresh-byte bypass apart from the stale tap. Plain recirculation lines and a mid-line stall show that the phase is kept. Lines with a mismatched select, or with `fetch_valid` set only on some cells, show that only matching fetches write, and only to the cells they fall on.

// File: rtl/txt_row_pkg.sv
package txt_row_pkg;
  typedef enum logic {SEL_CODE = 1'b0, SEL_ATTR = 1'b1} fetch_tgt_e;
  typedef enum logic {LINE_FIRST = 1'b0, LINE_SECOND = 1'b1} pair_pos_e;
  localparam int unsigned LANES = 2;
  localparam int unsigned LANE_CODE = 0;
  localparam int unsigned LANE_ATTR = 1;
endpackage

// File: rtl/fetch_route.sv
module fetch_route
  import txt_row_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic fetch_valid,
  input  logic fetch_sel,
  input  logic pair_second,
  output logic wr_code,
  output logic wr_attr
);
  fetch_tgt_e tgt;
  pair_pos_e  pos;

  always_comb begin
    tgt = fetch_tgt_e'(fetch_sel);
    pos = pair_pos_e'(pair_second);
    wr_code = shift_en && fetch_valid && (tgt == SEL_CODE) && (pos == LINE_FIRST);
    wr_attr = shift_en && fetch_valid && (tgt == SEL_ATTR) && (pos == LINE_SECOND);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst) !(wr_code && wr_attr)); // R6
  AST_NO_CODE_ON_SECOND: assert property (@(posedge clk) disable iff (rst) pair_second |-> !wr_code); // R6
  AST_NO_ATTR_ON_FIRST: assert property (@(posedge clk) disable iff (rst) !pair_second |-> !wr_attr); // R6
endmodule

// File: rtl/recirc_line.sv
module recirc_line #(
  parameter int unsigned CELLS = 40,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] tap
);
  localparam int unsigned LAST = CELLS - 1;

  logic [W-1:0] stg [CELLS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) stg[i] <= '0;
    end else if (shift_en) begin
      stg[0] <= wr_en ? wr_data : stg[LAST];
      for (int i = 1; i < CELLS; i++) stg[i] <= stg[i-1];
    end
  end

  assign tap = stg[LAST];

  AST_RECIRC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !wr_en) |=> stg[0] == $past(tap)); // R2
  AST_FETCH_INSERT: assert property (@(posedge clk) disable iff (rst)
    (shift_en && wr_en) |=> stg[0] == $past(wr_data)); // R3
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(tap)); // R7
endmodule

// File: rtl/disp_stage.sv
module disp_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         attr_fresh,
  input  logic [W-1:0] fresh_data,
  input  logic [W-1:0] code_tap,
  input  logic [W-1:0] attr_tap,
  output logic [W-1:0] cur_code,
  output logic [W-1:0] cur_attr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code <= '0;
      cur_attr <= '0;
    end else if (shift_en) begin
      cur_code <= code_tap;
      cur_attr <= attr_fresh ? fresh_data : attr_tap;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(cur_code) && $stable(cur_attr))); // R7
endmodule

// File: rtl/txt_row_recirc.sv
module txt_row_recirc
  import txt_row_pkg::*;
#(
  parameter int unsigned CELLS = 40,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         fetch_valid,
  input  logic         fetch_sel,
  input  logic         pair_second,
  input  logic [W-1:0] fetch_data,
  output logic [W-1:0] cur_code,
  output logic [W-1:0] cur_attr
);
  logic         wr_code, wr_attr;
  logic         lane_wr  [LANES];
  logic [W-1:0] lane_tap [LANES];

  fetch_route u_route (
    .clk(clk), .rst(rst), .shift_en(shift_en), .fetch_valid(fetch_valid),
    .fetch_sel(fetch_sel), .pair_second(pair_second),
    .wr_code(wr_code), .wr_attr(wr_attr)
  );

  assign lane_wr[LANE_CODE] = wr_code;
  assign lane_wr[LANE_ATTR] = wr_attr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    recirc_line #(.CELLS(CELLS), .W(W)) u_line (
      .clk(clk), .rst(rst), .shift_en(shift_en), .wr_en(lane_wr[g]),
      .wr_data(fetch_data), .tap(lane_tap[g])
    );
  end

  disp_stage #(.W(W)) u_disp (
    .clk(clk), .rst(rst), .shift_en(shift_en), .attr_fresh(wr_attr),
    .fresh_data(fetch_data), .code_tap(lane_tap[LANE_CODE]),
    .attr_tap(lane_tap[LANE_ATTR]), .cur_code(cur_code), .cur_attr(cur_attr)
  );

  AST_CODE_FROM_TAP: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cur_code == $past(lane_tap[LANE_CODE])); // R3
  AST_ATTR_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (shift_en && wr_attr) |=> cur_attr == $past(fetch_data)); // R4
  AST_ATTR_FROM_TAP: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !wr_attr) |=> cur_attr == $past(lane_tap[LANE_ATTR])); // R2
endmodule

// File: tb/sim_txt_row_recirc.sv
module sim_txt_row_recirc;
  localparam int CELLS = 40;

  logic       clk = 0;
  logic       rst = 1;
  logic       shift_en = 0, fetch_valid = 0, fetch_sel = 0, pair_second = 0;
  logic [7:0] fetch_data = 0;
  logic [7:0] cur_code, cur_attr;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [7:0] c;
    logic [7:0] a;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] mc [CELLS];
  logic [7:0] ma [CELLS];
  int pos = 0;
  logic pend = 0;

  always #10 clk = ~clk;

  txt_row_recirc #(.CELLS(CELLS), .W(8)) u0 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .fetch_valid(fetch_valid),
    .fetch_sel(fetch_sel), .pair_second(pair_second), .fetch_data(fetch_data),
    .cur_code(cur_code), .cur_attr(cur_attr)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= shift_en && !rst;

  always @(negedge clk) begin
    if (pend) begin
      if (q.size() == 0) check("R2 scoreboard underflow", 8'h01, 8'h00);
      else begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " code"}, cur_code, it.c);
        check({it.tag, " attr"}, cur_attr, it.a);
      end
    end
  end

  task automatic shift_cell(input logic fv, input logic sel, input logic sec,
                            input logic [7:0] d, input string tag);
    exp_t it;
    logic wc, wa;
    @(negedge clk);
    shift_en = 1; fetch_valid = fv; fetch_sel = sel; pair_second = sec; fetch_data = d;
    wc = fv && !sel && !sec;
    wa = fv && sel && sec;
    it.c = mc[pos];
    it.a = wa ? d : ma[pos];
    it.tag = tag;
    if (wc) mc[pos] = d;
    if (wa) ma[pos] = d;
    pos = (pos + 1) % CELLS;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shift_en = 0; fetch_valid = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; shift_en = 0; fetch_valid = 0;
    for (int i = 0; i < CELLS; i++) begin mc[i] = 0; ma[i] = 0; end
    pos = 0;
    idle(2);
    rst = 0;
    @(negedge clk);
    check("R1 reset code", cur_code, 8'h00);
    check("R1 reset attr", cur_attr, 8'h00);
  endtask

  task automatic plain_line(input string tag);
    for (int i = 0; i < CELLS; i++) shift_cell(0, 0, 0, 8'hEE, tag);
  endtask

  task automatic stall_check(input int n);
    logic [7:0] hc, ha;
    idle(1);
    hc = cur_code; ha = cur_attr;
    for (int i = 0; i < n; i++) begin
      idle(1);
      check("R7 stall code", cur_code, hc);
      check("R7 stall attr", cur_attr, ha);
    end
  endtask

  initial begin
    #(20 * 20000);
    check("watchdog", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    plain_line("R1 cleared row");
    // first line of pair: codes written, old codes shown
    for (int i = 0; i < CELLS; i++) shift_cell(1, 0, 0, 8'(i * 3 + 1), "R3 first line");
    // second line: attributes written and bypassed, new codes shown
    for (int i = 0; i < CELLS; i++) shift_cell(1, 1, 1, 8'hF0 ^ 8'(i), "R4 R5 second line");
    // recirculation with a mid-line stall
    for (int i = 0; i < 17; i++) shift_cell(0, 0, 0, 8'h00, "R2 recirc");
    stall_check(5);
    for (int i = 17; i < CELLS; i++) shift_cell(0, 0, 0, 8'h00, "R7 R2 after stall");
    // ignored fetches
    for (int i = 0; i < CELLS; i++) shift_cell(1, 1, 0, 8'h5A, "R6 attr sel on first");
    for (int i = 0; i < CELLS; i++) shift_cell(1, 0, 1, 8'hA5, "R6 code sel on second");
    for (int i = 0; i < CELLS; i++) shift_cell(0, i[0], i[1], 8'h3C, "R6 valid low");
    plain_line("R6 R2 row intact");
    // partial new pair, only even cells fetched
    for (int i = 0; i < CELLS; i++) shift_cell(!i[0], 0, 0, 8'h80 | 8'(i), "R3 partial codes");
    for (int i = 0; i < CELLS; i++) shift_cell(!i[0], 1, 1, 8'h40 + 8'(i), "R4 R5 partial attrs");
    plain_line("R2 after partial pair");
    idle(3);
    do_reset();
    plain_line("R1 after second reset");
    idle(3);
    check("R2 scoreboard drained", 8'(q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule